// File: doc/BRIEF.md
# Non-Power-of-Two Address Normalizer

This block turns a 64-bit system address, from which base and hole have already been removed, into the address seen inside one memory channel. The channel count is a multiple of three or five, so the channel-select information cannot be dropped simply by removing bits. It lives in an upper address field that must be divided by three or five. The block keeps the low byte as it is. It packs the retained middle bits just above that byte, with a packing that depends on the interleave granularity (1 KiB or 2 KiB). It then divides a mode-dependent upper field by the selected divisor and places the quotient above the middle bits. The remainder is discarded.

A request is a one-cycle `start` pulse with `addr`, `mode` and `sel_five` valid. The constant divider is a restoring radix-2 loop that resolves one quotient bit per clock. A legal request therefore keeps `busy` high while the quotient forms, and then raises `done` for one cycle with the result. An illegal mode skips the divider and completes at once, with a zero result and `err` set.

The controller has three states:
- ST_IDLE waits for work.
- ST_DIV runs the divider.
- ST_DONE is the single cycle in which `done` is high.

Its transitions are:
- IDLE→DIV on a start with a legal mode.
- IDLE→DONE on a start with an illegal mode.
- DIV→DIV while quotient bits remain.
- DIV→DONE on the last bit.
- DONE→DIV or DONE→DONE on a new start.
- DONE→IDLE otherwise.

Top module: `np2_addr_normalizer`

## Requirements
- R1: Result bits [7:0] equal address bits [7:0] in every legal mode.
- R2: mode[0] selects granularity (0 = 1K, 1 = 2K). For 1K, result bits [9:8] take address bits [11:10] and the quotient sits at bit 10. For 2K, result bits [10:8] take address bits [11:9] and the quotient sits at bit 11.
- R3: mode[2:1] = 0 is the 24-channel class. Its dividend is addr[63:13] (1K) or addr[63:14] (2K).
- R4: mode[2:1] = 1 is the 12-channel class. Its dividend is addr[63:12] (1K) or addr[63:13] (2K).
- R5: mode[2:1] = 2 is the 6/10-channel class. Its dividend is {addr[63:12], addr[9]} (1K) or addr[63:12] (2K).
- R6: mode[2:1] = 3 is the 3/5-channel class. Its dividend is {addr[63:12], addr[9:8]} (1K) or {addr[63:12], addr[8]} (2K).
- R7: `sel_five` = 1 divides by 5 and `sel_five` = 0 divides by 3. The quotient is exact and the remainder is discarded. Quotient bits shifted above bit 63 are lost.
- R8: mode[3] = 1 is illegal. Such a request gives result 0 and `err` = 1, with `done` high right after the accepting edge.
- R9: For a legal request, `busy` is high from the edge after acceptance until completion, and `done` rises on the 65th rising edge counting the accepting one. `done` lasts exactly one cycle, and `err` is 0 with it.
- R10: A `start` while `busy` is high is ignored: the running request completes with its own result.
- R11: After reset, `busy`, `done`, `err` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| addr | input | 64 | System address, base and hole removed |
| mode | input | 4 | {illegal, class[1:0], granularity} |
| sel_five | input | 1 | 1 divides by 5, 0 divides by 3 |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Completed request had an illegal mode |
| result | output | 64 | Normalized address, held until the next completion |

## Verification
A legal request completes 65 rising edges after its start, counting the accepting edge. An illegal one completes on the accepting edge itself, and `result` and `err` hold their values until the next completion. The bench drives and samples on falling edges. After each start it counts the falling edges until `done` is seen, checks that count against 65 or 1, and compares `result` at that same sample. One sample later it checks that `done` has dropped, which confirms the single-cycle pulse.

// File: rtl/np2_norm_pkg.sv
`timescale 1ns/1ps
package np2_norm_pkg;
    typedef enum logic [1:0] {
        CLS_24 = 2'd0,
        CLS_12 = 2'd1,
        CLS_6_10 = 2'd2,
        CLS_3_5 = 2'd3
    } chan_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_DONE = 2'd2
    } norm_st_e;

    localparam int unsigned LOW_BITS = 8;
    localparam int unsigned SHIFT_1K = 10;
    localparam int unsigned SHIFT_2K = 11;
endpackage

// File: rtl/np2_field_pick.sv
`timescale 1ns/1ps
module np2_field_pick
    import np2_norm_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        mode,
    output logic [ADDR_W-1:0] dividend,
    output logic [ADDR_W-1:0] kept,
    output logic              mode_ok,
    output logic              gran2k
);
    chan_cls_e cls;

    always_comb begin
        cls     = chan_cls_e'(mode[2:1]);
        mode_ok = ~mode[3];
        gran2k  = mode[0];

        kept = '0;
        kept[LOW_BITS-1:0] = addr[LOW_BITS-1:0];
        if (gran2k) kept[10:8] = addr[11:9];
        else        kept[9:8]  = addr[11:10];

        dividend = '0;
        unique case (cls)
            CLS_24:   dividend = gran2k ? (addr >> 14) : (addr >> 13);
            CLS_12:   dividend = gran2k ? (addr >> 13) : (addr >> 12);
            CLS_6_10: dividend = gran2k ? (addr >> 12)
                                        : (((addr >> 12) << 1) | ADDR_W'(addr[9]));
            CLS_3_5:  dividend = gran2k ? (((addr >> 12) << 1) | ADDR_W'(addr[8]))
                                        : (((addr >> 12) << 2) | ADDR_W'(addr[9:8]));
            default:  dividend = '0;
        endcase
        if (!mode_ok) dividend = '0;
    end
endmodule

// File: rtl/np2_const_div.sv
`timescale 1ns/1ps
module np2_const_div #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend,
    input  logic         sel_five,
    output logic [W-1:0] quotient_nxt
);
    localparam int unsigned REM_W = 3;

    logic [W-1:0]     quo_q;
    logic [REM_W-1:0] rem_q, rem_n;
    logic [REM_W:0]   dv_q;
    logic [REM_W:0]   trial;
    logic             ge;

    always_comb begin
        trial        = {rem_q, quo_q[W-1]};
        ge           = (trial >= dv_q);
        rem_n        = ge ? REM_W'(trial - dv_q) : trial[REM_W-1:0];
        quotient_nxt = {quo_q[W-2:0], ge};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dv_q  <= 4'd3;
        end else if (load) begin
            quo_q <= dividend;
            rem_q <= '0;
            dv_q  <= sel_five ? 4'd5 : 4'd3;
        end else if (step) begin
            quo_q <= quotient_nxt;
            rem_q <= rem_n;
        end
    end
endmodule

// File: rtl/np2_addr_normalizer.sv
`timescale 1ns/1ps
module np2_addr_normalizer
    import np2_norm_pkg::*;
#(
    parameter int unsigned ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        mode,
    input  logic              sel_five,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] result
);
    localparam int unsigned CNT_W = $clog2(ADDR_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W - 1);

    norm_st_e state_q, state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] dividend, kept, kept_q, quo_nxt;
    logic              mode_ok, gran2k, gran_q;
    logic              accept, load_div, step_div, last_step;

    np2_field_pick #(.ADDR_W(ADDR_W)) u_pick (
        .addr     (addr),
        .mode     (mode),
        .dividend (dividend),
        .kept     (kept),
        .mode_ok  (mode_ok),
        .gran2k   (gran2k)
    );

    np2_const_div #(.W(ADDR_W)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load_div),
        .step         (step_div),
        .dividend     (dividend),
        .sel_five     (sel_five),
        .quotient_nxt (quo_nxt)
    );

    assign accept    = start && (state_q != ST_DIV);
    assign load_div  = accept && mode_ok;
    assign step_div  = (state_q == ST_DIV);
    assign last_step = step_div && (cnt_q == LAST);
    assign busy      = (state_q == ST_DIV);

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept) state_n = mode_ok ? ST_DIV : ST_DONE;
                else        state_n = ST_IDLE;
            end
            ST_DIV:  if (last_step) state_n = ST_DONE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            kept_q <= '0;
            gran_q <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (step_div) cnt_q <= cnt_q + 1'b1;
            if (accept) begin
                cnt_q  <= '0;
                kept_q <= kept;
                gran_q <= gran2k;
                if (!mode_ok) begin
                    result <= '0;
                    err    <= 1'b1;
                    done   <= 1'b1;
                end
            end
            if (last_step) begin
                result <= (quo_nxt << (gran_q ? SHIFT_2K : SHIFT_1K)) | kept_q;
                err    <= 1'b0;
                done   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/np2_norm_checker.sv
`timescale 1ns/1ps
module np2_norm_checker #(
    parameter int unsigned ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        mode,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] result
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R9
    AST_LEGAL_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !mode[3]) |=> (busy && !done)); // R9
    AST_ILLEGAL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode[3]) |=> (done && err && result == '0)); // R8
    AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (result == '0)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done) |-> ($stable(result) && $stable(err))); // R10
endmodule

bind np2_addr_normalizer np2_norm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .mode   (mode),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .result (result)
);

// File: tb/np2_addr_normalizer_test.sv
`timescale 1ns/1ps
module np2_addr_normalizer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] addr = '0;
    logic [3:0]  mode = '0;
    logic        sel_five = 1'b0;
    logic        busy, done, err;
    logic [63:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    np2_addr_normalizer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .mode(mode),
        .sel_five(sel_five), .busy(busy), .done(done), .err(err), .result(result)
    );

    localparam int NV = 12;
    localparam logic [63:0] V_ADDR [NV] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_3000,
        64'hDEAD_BEEF_CAFE_F00D, 64'h8000_0000_0000_0300, 64'h0000_0ABC_DEF1_2345,
        64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_5FFF,
        64'h7FFF_FFFF_FFFF_E000, 64'h0000_0001_0000_0200, 64'h1357_9BDF_2468_ACE0
    };
    localparam logic [3:0] V_MODE [NV] = '{
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd7, 4'd0, 4'd4, 4'd6
    };
    localparam logic V_FIVE [NV] = '{
        1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0
    };

    function automatic logic [63:0] ref_norm(input logic [63:0] a, input logic [3:0] md,
                                             input logic five);
        logic [63:0] m, dvd, mid;
        int sh;
        m  = five ? 64'd5 : 64'd3;
        sh = md[0] ? 11 : 10;
        mid = md[0] ? {53'd0, a[11:9], 8'd0} : {54'd0, a[11:10], 8'd0};
        case (md[2:1])
            2'd0: dvd = md[0] ? {14'd0, a[63:14]} : {13'd0, a[63:13]};
            2'd1: dvd = md[0] ? {13'd0, a[63:13]} : {12'd0, a[63:12]};
            2'd2: dvd = md[0] ? {12'd0, a[63:12]} : {11'd0, a[63:12], a[9]};
            default: dvd = md[0] ? {11'd0, a[63:12], a[8]} : {10'd0, a[63:12], a[9:8]};
        endcase
        return ((dvd / m) << sh) | mid | {56'd0, a[7:0]};
    endfunction

    function automatic string tag_of(input logic [3:0] md);
        case (md[2:1])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pulse start for one cycle, then count falling-edge samples until done.
    // If dup is set, a second start with other inputs is pulsed while busy.
    task automatic run(input logic [63:0] a, input logic [3:0] md, input logic five,
                       input bit dup, output logic [63:0] res, output logic e,
                       output int lat);
        @(negedge clk);
        addr = a; mode = md; sel_five = five; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            if (dup && lat == 10) begin
                addr = ~a; mode = 4'd3; sel_five = ~five; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        res = result;
        e = err;
        @(negedge clk);
        chk(!done, "R9 done width", {63'd0, done}, 64'd0);
    endtask

    initial begin
        #600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] r, ex;
        logic e;
        int lat;

        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && result == 0, "R11 reset",
            {busy, done, err, result[60:0]}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            ex = ref_norm(V_ADDR[i], V_MODE[i], V_FIVE[i]);
            run(V_ADDR[i], V_MODE[i], V_FIVE[i], 1'b0, r, e, lat);
            chk(r == ex, tag_of(V_MODE[i]), r, ex);
            chk(!e && lat == 65, "R9 latency", 64'(lat), 64'd65);
            chk(r[7:0] == V_ADDR[i][7:0], "R1 low byte", {56'd0, r[7:0]},
                {56'd0, V_ADDR[i][7:0]});
        end

        // R4 with divide by 3: dividend 3 gives quotient 1 at bit 10
        run(64'h3000, 4'd2, 1'b0, 1'b0, r, e, lat);
        chk(r == 64'h400, "R4 R7 div3", r, 64'h400);
        // R2 2K packing, R6 and R7: dividend 11 / 5 = 2 at bit 11, mid 7, low FF
        run(64'h5FFF, 4'd7, 1'b1, 1'b0, r, e, lat);
        chk(r == 64'h17FF, "R2 R6 R7 div5", r, 64'h17FF);
        // R7 remainder dropped: dividend 4 / 5 = 0, result keeps only low bits
        run(64'h4C12, 4'd2, 1'b1, 1'b0, r, e, lat);
        chk(r == 64'h0312, "R7 remainder", r, 64'h0312);
        // R2 1K packing: only addr[11:10] land in result[9:8]
        run(64'h0E00, 4'd0, 1'b0, 1'b0, r, e, lat);
        chk(r == 64'h0300, "R2 1K mid", r, 64'h0300);

        // R8 illegal modes
        run(64'hFFFF_0000_1234_5678, 4'd8, 1'b0, 1'b0, r, e, lat);
        chk(r == 0 && e && lat == 1, "R8 illegal 8", {r[62:0], e}, 64'd1);
        run(64'h1111_2222_3333_4444, 4'd15, 1'b1, 1'b0, r, e, lat);
        chk(r == 0 && e && lat == 1, "R8 illegal 15", {r[62:0], e}, 64'd1);
        run(64'h3000, 4'd2, 1'b0, 1'b0, r, e, lat);
        chk(!e && r == 64'h400, "R8 err clears", {r[62:0], e}, 64'h800);

        // R10 start while busy is ignored
        ex = ref_norm(64'h0123_4567_89AB_CDEF, 4'd5, 1'b0);
        run(64'h0123_4567_89AB_CDEF, 4'd5, 1'b0, 1'b1, r, e, lat);
        chk(r == ex && lat == 65, "R10 ignored start", r, ex);
        @(negedge clk);
        chk(!busy && !done, "R10 no second run", {62'd0, busy, done}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule